// File: doc/BRIEF.md
# Memory-mapped terminal receiver/transmitter controller

This block is a bus-attached character terminal controller. Software sees four word registers at a fixed base address: a receiver control word, a receiver data word, a transmitter control word and a transmitter data word. A load from the receiver data word returns the last received byte. A store to the transmitter data word sends a byte out. Each control word holds a ready flag and an interrupt-enable flag. The receiver control word also holds a sticky overrun flag.

On the device side, received bytes arrive as a one-cycle byte strobe. Outgoing bytes leave on a valid/ready stream: the byte is held until the sink accepts it. A single level interrupt request is raised while any channel is ready with its enable set. Software can therefore use polling, interrupts, or both.

Register reads are combinational in the cycle of the request. All side effects take place at the clock edge that ends the request.

Top module: `term_mmio_ctrl`

## Requirements
- R1: The registers decode at BASE_ADDR (default 0xFFFF0000) plus an offset: receiver control at 0x0, receiver data at 0x4, transmitter control at 0x8, transmitter data at 0xC. An access whose address bits above bit 3 differ from BASE_ADDR reads 0 and writes nothing. Read data is 0 whenever no read request is active.
- R2: Control word fields are bit 0 = ready and bit 1 = interrupt enable. The receiver control word also has bit 2 = overrun. Data words carry the byte in bits 7:0. Every other bit reads 0.
- R3: A byte strobed on rx_valid_i is stored in the receiver data word, and the receiver ready flag reads 1 from the next cycle.
- R4: A read of the receiver data word clears the receiver ready flag at the end of the access. If a new byte arrives in the same cycle, the flag stays set.
- R5: A byte that arrives while the receiver ready flag is set, and is not being read in that cycle, replaces the stored byte and sets the overrun flag. A read of the receiver control word clears the overrun flag.
- R6: After reset the transmitter ready flag is 1. A write to the transmitter data word while ready is set does three things from the next cycle: it drives the byte on tx_byte_o, raises tx_valid_o, and clears ready.
- R7: While tx_valid_o is high and tx_ready_i is low, tx_byte_o holds. A write to the transmitter data word while ready is 0 is ignored. A cycle with both tx_valid_o and tx_ready_i high sets ready again and drops tx_valid_o from the next cycle.
- R8: A write to a control word changes only its interrupt-enable flag, taken from write data bit 1. The ready and overrun flags are not changed by it.
- R9: irq_o is high exactly when the receiver is ready with its enable set, or the transmitter is ready with its enable set.
- R10: Reset (rst_ni low) clears both enables, receiver ready, overrun and both data bytes. irq_o and tx_valid_o are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data, valid in the request cycle |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | DATA_W | Received byte |
| tx_valid_o | output | 1 | Outgoing byte is valid |
| tx_byte_o | output | DATA_W | Outgoing byte |
| tx_ready_i | input | 1 | Sink accepts the outgoing byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong flag is visible at the ports within one cycle. irq_o follows the registered flags directly, and a read of a control word in the next request shows every flag bit. A stuck receiver ready flag appears as an unexpected 1 in bit 0, and a missed overrun appears as a missing bit 2. A transmitter handshake fault shows on tx_valid_o or tx_byte_o in the cycle after the write or the acceptance. The directed sequences cover several cases: a read and an arrival in the same cycle, a write to a busy transmitter, and accesses outside the decoded range.

// File: rtl/term_pkg.sv
`timescale 1ns/1ps
package term_pkg;
  typedef enum logic [1:0] {
    SEL_RX_CTRL = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_CTRL = 2'd2,
    SEL_TX_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_sel_e sel;
  } acc_t;

  localparam int unsigned READY_BIT = 0;
  localparam int unsigned IE_BIT    = 1;
  localparam int unsigned OVR_BIT   = 2;
  localparam int unsigned REG_LSB   = 2;
  localparam int unsigned MAP_LSB   = 4;
endpackage

// File: rtl/term_addr_dec.sv
`timescale 1ns/1ps
module term_addr_dec
  import term_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  logic hit;

  assign hit = (addr_i[ADDR_W-1:MAP_LSB] == BASE_ADDR[ADDR_W-1:MAP_LSB]);

  always_comb begin
    acc_o.rd  = req_i & ~we_i & hit;
    acc_o.wr  = req_i &  we_i & hit;
    acc_o.sel = reg_sel_e'(addr_i[MAP_LSB-1:REG_LSB]);
  end
endmodule

// File: rtl/term_rx_chan.sv
`timescale 1ns/1ps
module term_rx_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ctrl_wr_i,
  input  logic              ie_wdata_i,
  input  logic              ctrl_rd_i,
  input  logic              data_rd_i,
  output logic              ready_o,
  output logic              ie_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              ready_q, ie_q, ovr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      ie_q    <= 1'b0;
      ovr_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (ctrl_wr_i) ie_q <= ie_wdata_i;
      if (byte_valid_i) begin
        data_q  <= byte_i;
        ready_q <= 1'b1;
      end else if (data_rd_i) begin
        ready_q <= 1'b0;
      end
      // an unread byte is lost: set wins over read-clear
      if (byte_valid_i && ready_q && !data_rd_i) ovr_q <= 1'b1;
      else if (ctrl_rd_i)                        ovr_q <= 1'b0;
    end
  end

  assign ready_o = ready_q;
  assign ie_o    = ie_q;
  assign ovr_o   = ovr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/term_tx_chan.sv
`timescale 1ns/1ps
module term_tx_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ctrl_wr_i,
  input  logic              ie_wdata_i,
  input  logic              dev_ready_i,
  output logic              ready_o,
  output logic              ie_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o
);
  logic              ready_q, ie_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      ie_q    <= 1'b0;
      byte_q  <= '0;
    end else begin
      if (ctrl_wr_i) ie_q <= ie_wdata_i;
      if (data_wr_i && ready_q) begin
        byte_q  <= wdata_i;
        ready_q <= 1'b0;
      end else if (!ready_q && dev_ready_i) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
  assign ie_o    = ie_q;
  assign valid_o = ~ready_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/term_mmio_ctrl.sv
`timescale 1ns/1ps
module term_mmio_ctrl
  import term_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  acc_t              acc;
  logic              rx_ready, rx_ie, rx_ovr;
  logic              tx_ready, tx_ie;
  logic [DATA_W-1:0] rx_data;
  logic              unused_bits;

  assign unused_bits = ^{addr_i[REG_LSB-1:0], wdata_i[BUS_W-1:DATA_W]};

  term_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .acc_o (acc)
  );

  term_rx_chan #(.DATA_W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(rx_valid_i),
    .byte_i      (rx_byte_i),
    .ctrl_wr_i   (acc.wr && acc.sel == SEL_RX_CTRL),
    .ie_wdata_i  (wdata_i[IE_BIT]),
    .ctrl_rd_i   (acc.rd && acc.sel == SEL_RX_CTRL),
    .data_rd_i   (acc.rd && acc.sel == SEL_RX_DATA),
    .ready_o     (rx_ready),
    .ie_o        (rx_ie),
    .ovr_o       (rx_ovr),
    .data_o      (rx_data)
  );

  term_tx_chan #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (acc.wr && acc.sel == SEL_TX_DATA),
    .wdata_i    (wdata_i[DATA_W-1:0]),
    .ctrl_wr_i  (acc.wr && acc.sel == SEL_TX_CTRL),
    .ie_wdata_i (wdata_i[IE_BIT]),
    .dev_ready_i(tx_ready_i),
    .ready_o    (tx_ready),
    .ie_o       (tx_ie),
    .valid_o    (tx_valid_o),
    .byte_o     (tx_byte_o)
  );

  always_comb begin
    rdata_o = '0;
    if (acc.rd) begin
      unique case (acc.sel)
        SEL_RX_CTRL: begin
          rdata_o[READY_BIT] = rx_ready;
          rdata_o[IE_BIT]    = rx_ie;
          rdata_o[OVR_BIT]   = rx_ovr;
        end
        SEL_RX_DATA: rdata_o[DATA_W-1:0] = rx_data;
        SEL_TX_CTRL: begin
          rdata_o[READY_BIT] = tx_ready;
          rdata_o[IE_BIT]    = tx_ie;
        end
        SEL_TX_DATA: rdata_o[DATA_W-1:0] = tx_byte_o;
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (rx_ready & rx_ie) | (tx_ready & tx_ie);
endmodule

// File: rtl/term_mmio_ctrl_chk.sv
`timescale 1ns/1ps
module term_mmio_ctrl_chk
  import term_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input reg_sel_e          sel_i,
  input logic [DATA_W-1:0] wbyte_i,
  input logic              rx_valid_i,
  input logic              rx_ready_i,
  input logic              rx_ovr_i,
  input logic              rx_ie_i,
  input logic              tx_rdy_flag_i,
  input logic              tx_ie_i,
  input logic              tx_valid_i,
  input logic              tx_sink_rdy_i,
  input logic [DATA_W-1:0] tx_byte_i,
  input logic              irq_i
);
  assert_rx_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_ready_i);

  assert_rx_read_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_RX_DATA && !rx_valid_i) |=> !rx_ready_i);

  assert_overrun_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_i && !(rd_i && sel_i == SEL_RX_DATA)) |=> rx_ovr_i);

  assert_tx_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_TX_DATA && tx_rdy_flag_i) |=> (tx_valid_i && tx_byte_i == $past(wbyte_i)));

  assert_tx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_sink_rdy_i) |=> (tx_valid_i && $stable(tx_byte_i)));

  assert_rx_ctrl_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_RX_CTRL && !rx_valid_i) |=> ($stable(rx_ready_i) && $stable(rx_ovr_i)));

  assert_tx_ctrl_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_TX_CTRL && !(tx_valid_i && tx_sink_rdy_i)) |=> $stable(tx_rdy_flag_i));

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (rx_ie_i || tx_ie_i));
endmodule

bind term_mmio_ctrl term_mmio_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (acc.rd),
  .wr_i         (acc.wr),
  .sel_i        (acc.sel),
  .wbyte_i      (wdata_i[DATA_W-1:0]),
  .rx_valid_i   (rx_valid_i),
  .rx_ready_i   (rx_ready),
  .rx_ovr_i     (rx_ovr),
  .rx_ie_i      (rx_ie),
  .tx_rdy_flag_i(tx_ready),
  .tx_ie_i      (tx_ie),
  .tx_valid_i   (tx_valid_o),
  .tx_sink_rdy_i(tx_ready_i),
  .tx_byte_i    (tx_byte_o),
  .irq_i        (irq_o)
);

// File: tb/sim_term_mmio_ctrl.sv
`timescale 1ns/1ps
module sim_term_mmio_ctrl;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [3:0] O_RXC = 4'h0, O_RXD = 4'h4, O_TXC = 4'h8, O_TXD = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic        rxv = 1'b0;
  logic [7:0]  rxb = '0;
  logic        txv, txr = 1'b0, irq;
  logic [7:0]  txb;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  term_mmio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rxv), .rx_byte_i(rxb),
    .tx_valid_o(txv), .tx_byte_o(txb), .tx_ready_i(txr), .irq_o(irq)
  );

  typedef struct packed {
    logic        rq;
    logic        w;
    logic [3:0]  off;
    logic [7:0]  wd;
    logic        rv;
    logic [7:0]  rb;
    logic        tr;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  // irq expectation reflects state before the step's edge
  localparam vec_t VECS [15] = '{
    '{1'b1, 1'b0, O_RXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h0,  1'b0}, // R10 rx ctrl reset
    '{1'b1, 1'b0, O_TXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h1,  1'b0}, // R6 tx ready at reset
    '{1'b1, 1'b1, O_TXC, 8'h02, 1'b0, 8'h00, 1'b0, 32'h0,  1'b0}, // R8 set tx ie
    '{1'b1, 1'b0, O_TXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h3,  1'b1}, // R9 irq from tx
    '{1'b1, 1'b1, O_TXD, 8'h41, 1'b0, 8'h00, 1'b0, 32'h0,  1'b1}, // R6 load byte
    '{1'b1, 1'b0, O_TXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h2,  1'b0}, // R6 ready cleared
    '{1'b1, 1'b0, O_TXD, 8'h00, 1'b0, 8'h00, 1'b1, 32'h41, 1'b0}, // R7 accept
    '{1'b1, 1'b0, O_TXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h3,  1'b1}, // R7 ready back
    '{1'b1, 1'b1, O_TXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h0,  1'b1}, // R8 clear tx ie
    '{1'b0, 1'b0, O_RXC, 8'h00, 1'b1, 8'h5A, 1'b0, 32'h0,  1'b0}, // R3 byte arrives
    '{1'b1, 1'b0, O_RXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h1,  1'b0}, // R3 ready set
    '{1'b1, 1'b1, O_RXC, 8'h03, 1'b0, 8'h00, 1'b0, 32'h0,  1'b0}, // R8 bit0 ignored
    '{1'b1, 1'b0, O_RXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h3,  1'b1}, // R9 irq from rx
    '{1'b1, 1'b0, O_RXD, 8'h00, 1'b0, 8'h00, 1'b0, 32'h5A, 1'b1}, // R2 data word
    '{1'b1, 1'b0, O_RXC, 8'h00, 1'b0, 8'h00, 1'b0, 32'h2,  1'b0}  // R4 read cleared
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, return 2 ns later for sampling
  task automatic step(input logic rq, input logic w, input logic [31:0] a,
                      input logic [31:0] wd, input logic rv, input logic [7:0] rb,
                      input logic tr);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = wd; rxv = rv; rxb = rb; txr = tr;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, BASE, '0, 1'b0, '0, 1'b0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    chk("R10 tx_valid after reset", {31'b0, txv}, 32'h0);
    chk("R1 idle rdata", rdata, 32'h0);

    foreach (VECS[i]) begin
      step(VECS[i].rq, VECS[i].w, BASE | {28'b0, VECS[i].off}, {24'hABCDEF, VECS[i].wd},
           VECS[i].rv, VECS[i].rb, VECS[i].tr);
      if (!VECS[i].w) chk($sformatf("R2 table rdata step %0d", i), rdata, VECS[i].exp_rd);
      chk($sformatf("R9 table irq step %0d", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
      if (i == 5) chk("R6 tx_byte driven", {24'b0, txb}, 32'h41);
    end

    // R5 overrun: two bytes without a read
    step(1'b0, 1'b0, BASE, '0, 1'b1, 8'h11, 1'b0);
    step(1'b0, 1'b0, BASE, '0, 1'b1, 8'h22, 1'b0);
    step(1'b1, 1'b0, BASE | O_RXC, '0, 1'b0, '0, 1'b0);
    chk("R5 overrun set", rdata, 32'h7);
    step(1'b1, 1'b0, BASE | O_RXC, '0, 1'b0, '0, 1'b0);
    chk("R5 overrun cleared by ctrl read", rdata, 32'h3);
    step(1'b1, 1'b0, BASE | O_RXD, '0, 1'b0, '0, 1'b0);
    chk("R5 newest byte kept", rdata, 32'h22);

    // R4 read and arrival in the same cycle
    step(1'b0, 1'b0, BASE, '0, 1'b1, 8'h33, 1'b0);
    step(1'b1, 1'b0, BASE | O_RXD, '0, 1'b1, 8'h44, 1'b0);
    chk("R4 read returns older byte", rdata, 32'h33);
    step(1'b1, 1'b0, BASE | O_RXC, '0, 1'b0, '0, 1'b0);
    chk("R4 ready kept, no overrun", rdata, 32'h3);
    step(1'b1, 1'b0, BASE | O_RXD, '0, 1'b0, '0, 1'b0);
    chk("R4 second byte", rdata, 32'h44);
    step(1'b1, 1'b0, BASE | O_RXC, '0, 1'b0, '0, 1'b0);
    chk("R4 ready cleared", rdata, 32'h2);

    // R7 write while busy is ignored, byte held under backpressure
    step(1'b1, 1'b1, BASE | O_TXD, 32'h41, 1'b0, '0, 1'b0);
    step(1'b1, 1'b1, BASE | O_TXD, 32'h42, 1'b0, '0, 1'b0);
    chk("R7 valid while waiting", {31'b0, txv}, 32'h1);
    step(1'b0, 1'b0, BASE, '0, 1'b0, '0, 1'b0);
    chk("R7 busy write ignored", {24'b0, txb}, 32'h41);
    step(1'b0, 1'b0, BASE, '0, 1'b0, '0, 1'b1);
    chk("R7 valid during accept", {31'b0, txv}, 32'h1);
    step(1'b1, 1'b0, BASE | O_TXC, '0, 1'b0, '0, 1'b0);
    chk("R7 valid dropped after accept", {31'b0, txv}, 32'h0);
    chk("R7 ready after accept", rdata, 32'h1);

    // R1 accesses outside the map
    step(1'b1, 1'b1, 32'h0000_0008, 32'h2, 1'b0, '0, 1'b0);
    step(1'b1, 1'b0, BASE | O_TXC, '0, 1'b0, '0, 1'b0);
    chk("R1 off-map write ignored", rdata, 32'h1);
    step(1'b1, 1'b0, BASE + 32'h18, '0, 1'b0, '0, 1'b0);
    chk("R1 off-map read zero", rdata, 32'h0);
    step(1'b0, 1'b0, BASE | O_TXC, '0, 1'b0, '0, 1'b0);
    chk("R1 no request reads zero", rdata, 32'h0);

    // R10 reset in mid-operation
    step(1'b1, 1'b1, BASE | O_TXD, 32'h55, 1'b0, '0, 1'b0);
    @(negedge clk);
    req = 1'b0; rst_n = 1'b0;
    #2;
    chk("R10 tx_valid cleared by reset", {31'b0, txv}, 32'h0);
    chk("R10 tx byte cleared", {24'b0, txb}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, BASE | O_RXC, '0, 1'b0, '0, 1'b0);
    chk("R10 rx ctrl after reset", rdata, 32'h0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule